// File: doc/BRIEF.md
# Frame-synchronized USB transmit FIFO

This block buffers outgoing bytes for one USB device IN endpoint. Firmware pushes bytes one at a time and then closes a packet, called a data set, by writing its byte count. Up to two closed data sets can wait in a shared byte store. A USB-side engine asks for a response type whenever an IN token arrives. When the answer is data, it pops the bytes one strobe at a time. Serialization, CRC and token decoding are handled elsewhere.

The block reports four flags and a two-bit set count. The flags are: no bytes staged for the next set, store full, underrun, and overflow. It runs in one of two modes. In bulk-style mode a closed set is offered to the host at once. In isochronous mode the block follows the frame: a set closed during a frame is offered only from the next start-of-frame (SOF) pulse on. Effects of USB activity, such as retiring a sent set or flagging an underrun, are held back until that pulse. Effects of firmware activity apply at once. At an SOF, an offered set that was not fully sent is discarded when a newer set is already waiting, so a set closed late never shifts the frame alignment for good.

Top module: `usb_tx_frame_fifo`

## Requirements
- R1: After reset, and one cycle after `fw_clear`, the block is in its idle state. In that state `flag_empty` is 1, `flag_full`, `flag_underrun` and `flag_overflow` are 0, `set_count` is 00 and `resp_valid` is 0. Any stored bytes and sets are discarded.
- R2: `flag_empty` is 1 while no byte has been accepted since the last accepted commit or clear. It goes to 0 one cycle after the first accepted byte and returns to 1 after an accepted commit.
- R3: `flag_full` is 1 while the number of bytes held equals DEPTH. Bytes held are those written and not yet popped or discarded. A write while full is dropped.
- R4: A `fw_commit` with a nonzero `fw_commit_len` closes a set, and `set_count` gives the number of closed sets held: 00 for none, 01 for one, 10 for two. A commit whose length is zero is ignored.
- R5: A nonzero commit while `set_count` is 10 is ignored, and `flag_overflow` goes to 1 on the next cycle. `flag_overflow` stays at 1 until `fw_clear`.
- R6: Each accepted `usb_rd` pops one byte, in write order, and the byte appears on `usb_rd_data` one cycle later. A set is retired once its count of bytes has been popped. In bulk-style mode `set_count` drops one cycle after the final pop.
- R7: A `usb_rd` is an underrun when the offered set is not finished and no byte is held. In that case the read position does not move. After an underrun, reads are refused until `fw_clear`, and only `fw_clear` clears `flag_underrun`.
- R8: `resp_valid` pulses for one cycle, one cycle after `in_token`. `resp_kind` is 00 for data, 01 for a zero-length packet and 10 for NACK. While `flag_underrun` is 1, every response is NACK.
- R9: In bulk-style mode (`iso_mode`=0), a closed set is offered at once. An IN token that finds no unfinished set gets NACK.
- R10: In isochronous mode, a set closed in a frame is hidden until the next `sof`. An IN token that finds no offered, unfinished set gets a zero-length response. This includes the case where the offered set has already been fully sent in this frame.
- R11: In isochronous mode, underrun flagging and set retirement wait for the next `sof`: `flag_underrun` and the drop in `set_count` appear one cycle after that pulse. A `usb_rd` in the same cycle as `sof` is ignored.
- R12: In isochronous mode, at `sof`, a set that was offered but is unfinished is discarded when a second set is held, and the second set becomes the offered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_data | input | 8 | Firmware byte |
| fw_commit | input | 1 | Close the staged set |
| fw_commit_len | input | CW | Byte count of the set being closed |
| fw_clear | input | 1 | Flush store and clear all flags |
| iso_mode | input | 1 | 1 selects isochronous behaviour |
| sof | input | 1 | Start-of-frame pulse |
| in_token | input | 1 | IN token seen, response requested |
| usb_rd | input | 1 | Pop one byte |
| usb_rd_data | output | 8 | Popped byte, one cycle after `usb_rd` |
| flag_empty | output | 1 | Nothing staged for the next set |
| flag_full | output | 1 | Store holds DEPTH bytes |
| flag_underrun | output | 1 | Sticky underrun |
| flag_overflow | output | 1 | Sticky overflow on commit |
| set_count | output | 2 | Closed sets held |
| resp_valid | output | 1 | Response strobe |
| resp_kind | output | 2 | 00 data, 01 zero-length, 10 NACK |

## Verification
The bench walks every set length from one byte up to DEPTH in bulk-style mode, so the pointers wrap several times. A design with a wrong wrap or a wrong retire count would return the wrong bytes or leave a phantom set. It closes the two sets that fill the queue and then closes a third, expecting an ignored commit and a sticky overflow rather than a corrupted count. In isochronous mode it probes a token before the SOF, after a set was fully sent, and across an underrun in mid-frame. A design that offers sets early, retires them at once or flags the underrun at once gives the wrong response or flag in that window. Finally it holds a stale set across a frame while a new one waits, and expects the bytes of the new set after the SOF; a design without the discard sends the old ones.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    RESP_DATA = 2'b00,
    RESP_ZLP  = 2'b01,
    RESP_NACK = 2'b10
  } resp_e;
endpackage

// File: rtl/utx_byte_ram.sv
module utx_byte_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int W     = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/utx_resp_gen.sv
module utx_resp_gen
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_token,
  input  logic       iso,
  input  logic       urun,
  input  logic       data_ready,
  output logic       resp_valid,
  output logic [1:0] resp_kind
);
  resp_e kind_d;

  always_comb begin
    if (urun)            kind_d = RESP_NACK;
    else if (data_ready) kind_d = RESP_DATA;
    else if (iso)        kind_d = RESP_ZLP;
    else                 kind_d = RESP_NACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_kind  <= RESP_NACK;
    end else begin
      resp_valid <= in_token;
      if (in_token) resp_kind <= kind_d;
    end
  end
endmodule

// File: rtl/usb_tx_frame_fifo.sv
module usb_tx_frame_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fw_wr_en,
  input  logic [7:0]    fw_wr_data,
  input  logic          fw_commit,
  input  logic [CW-1:0] fw_commit_len,
  input  logic          fw_clear,
  input  logic          iso_mode,
  input  logic          sof,
  input  logic          in_token,
  input  logic          usb_rd,
  output logic [7:0]    usb_rd_data,
  output logic          flag_empty,
  output logic          flag_full,
  output logic          flag_underrun,
  output logic          flag_overflow,
  output logic [1:0]    set_count,
  output logic          resp_valid,
  output logic [1:0]    resp_kind
);
  // byte store pointers and fill levels
  logic [AW-1:0] wp, rp, rp_next;
  logic [CW-1:0] occ, occ_next, staged;
  // two set slots
  logic [CW-1:0] slen [2];
  logic [1:0]    spres, svis, spres_kept, svis_next;
  logic          hd;
  logic [CW-1:0] rd_cnt;
  logic          urun, urun_pend, ovf;

  logic [1:0]    cnt;
  logic          head_pres, head_vis, head_fin, tgt;
  logic [CW-1:0] head_len, rem_len, flush_amt;
  logic          wr_ok, rd_ok, rd_under, commit_ok, commit_ovf, remove, flush;

  function automatic logic [AW-1:0] ptr_add(input logic [AW-1:0] p, input logic [CW-1:0] k);
    logic [CW:0] s;
    s = (CW+1)'(p) + (CW+1)'(k);
    if (s >= (CW+1)'(DEPTH)) s = s - (CW+1)'(DEPTH);
    return s[AW-1:0];
  endfunction

  always_comb begin
    cnt       = {1'b0, spres[0]} + {1'b0, spres[1]};
    head_pres = spres[hd];
    head_len  = slen[hd];
    head_vis  = head_pres && (svis[hd] || !iso_mode);
    head_fin  = head_pres && (rd_cnt == head_len);
    tgt       = (cnt == 2'd0) ? hd : ~hd;

    wr_ok      = fw_wr_en && (occ != CW'(DEPTH));
    commit_ok  = fw_commit && (fw_commit_len != '0) && (cnt != 2'd2);
    commit_ovf = fw_commit && (fw_commit_len != '0) && (cnt == 2'd2);

    rd_ok    = usb_rd && head_vis && !head_fin && !urun && !urun_pend &&
               !(iso_mode && sof) && (occ != '0);
    rd_under = usb_rd && head_vis && !head_fin && !urun && !urun_pend &&
               !(iso_mode && sof) && (occ == '0);

    flush  = iso_mode && sof && !head_fin && head_vis && (cnt == 2'd2);
    remove = (!iso_mode && head_fin) || (iso_mode && sof && head_fin) || flush;

    rem_len   = head_len - rd_cnt;
    flush_amt = '0;
    if (flush) flush_amt = (rem_len > occ) ? occ : rem_len;

    if (rd_ok)      rp_next = ptr_add(rp, CW'(1));
    else if (flush) rp_next = ptr_add(rp, flush_amt);
    else            rp_next = rp;

    occ_next = occ + CW'(wr_ok) - CW'(rd_ok) - flush_amt;

    spres_kept = spres;
    if (remove) spres_kept[hd] = 1'b0;
    svis_next = svis;
    if (iso_mode && sof) svis_next = spres_kept;
    if (commit_ok) svis_next[tgt] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || fw_clear) begin
      wp        <= '0;
      rp        <= '0;
      occ       <= '0;
      staged    <= '0;
      spres     <= '0;
      svis      <= '0;
      hd        <= 1'b0;
      rd_cnt    <= '0;
      urun      <= 1'b0;
      urun_pend <= 1'b0;
      ovf       <= 1'b0;
      slen[0]   <= '0;
      slen[1]   <= '0;
    end else begin
      if (wr_ok) wp <= ptr_add(wp, CW'(1));
      rp  <= rp_next;
      occ <= occ_next;

      if (commit_ok)  staged <= CW'(wr_ok);
      else if (wr_ok) staged <= staged + CW'(1);

      if (commit_ovf) ovf <= 1'b0 | 1'b1;

      spres <= spres_kept;
      if (commit_ok) begin
        spres[tgt] <= 1'b1;
        slen[tgt]  <= fw_commit_len;
      end
      svis <= svis_next;

      if (remove) begin
        hd     <= ~hd;
        rd_cnt <= '0;
      end else if (rd_ok) begin
        rd_cnt <= rd_cnt + CW'(1);
      end

      if (rd_under) begin
        if (iso_mode) urun_pend <= 1'b1;
        else          urun      <= 1'b1;
      end
      if (sof && urun_pend) begin
        urun      <= 1'b1;
        urun_pend <= 1'b0;
      end
    end
  end

  utx_byte_ram #(.DEPTH(DEPTH), .AW(AW), .W(8)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wp),
    .wdata (fw_wr_data),
    .re    (rd_ok),
    .raddr (rp),
    .rdata (usb_rd_data)
  );

  utx_resp_gen u_resp (
    .clk        (clk),
    .rst        (rst),
    .in_token   (in_token),
    .iso        (iso_mode),
    .urun       (urun),
    .data_ready (head_vis && !head_fin),
    .resp_valid (resp_valid),
    .resp_kind  (resp_kind)
  );

  assign flag_empty    = (staged == '0);
  assign flag_full     = (occ == CW'(DEPTH));
  assign flag_underrun = urun;
  assign flag_overflow = ovf;
  assign set_count     = cnt;
endmodule

// File: rtl/usb_tx_frame_fifo_chk.sv
module usb_tx_frame_fifo_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          fw_commit,
  input logic [CW-1:0] fw_commit_len,
  input logic          fw_clear,
  input logic          iso_mode,
  input logic          sof,
  input logic          in_token,
  input logic          flag_empty,
  input logic          flag_full,
  input logic          flag_underrun,
  input logic          flag_overflow,
  input logic [1:0]    set_count,
  input logic          resp_valid,
  input logic [1:0]    resp_kind
);
  // R1
  clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fw_clear |=> (flag_empty && !flag_full && !flag_underrun && !flag_overflow && set_count == 2'b00));

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    set_count != 2'b11);

  // R5
  overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (fw_commit && fw_commit_len != '0 && set_count == 2'b10 && !fw_clear) |=> flag_overflow);

  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_overflow && !fw_clear) |=> flag_overflow);

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_underrun && !fw_clear) |=> flag_underrun);

  // R8
  nack_on_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    (in_token && flag_underrun) |=> (resp_valid && resp_kind == 2'b10));

  // R9
  bulk_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (!iso_mode && in_token && set_count == 2'b00) |=> (resp_valid && resp_kind == 2'b10));

  // R10
  iso_zlp_chk: assert property (@(posedge clk) disable iff (rst)
    (iso_mode && in_token && set_count == 2'b00 && !flag_underrun) |=> (resp_valid && resp_kind == 2'b01));

  // R11
  iso_defer_chk: assert property (@(posedge clk) disable iff (rst)
    (iso_mode && !sof && !fw_clear) |=> $stable(flag_underrun));
endmodule

bind usb_tx_frame_fifo usb_tx_frame_fifo_chk #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fw_commit     (fw_commit),
  .fw_commit_len (fw_commit_len),
  .fw_clear      (fw_clear),
  .iso_mode      (iso_mode),
  .sof           (sof),
  .in_token      (in_token),
  .flag_empty    (flag_empty),
  .flag_full     (flag_full),
  .flag_underrun (flag_underrun),
  .flag_overflow (flag_overflow),
  .set_count     (set_count),
  .resp_valid    (resp_valid),
  .resp_kind     (resp_kind)
);

// File: tb/usb_tx_frame_fifo_test.sv
module usb_tx_frame_fifo_test;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int K_DATA = 0, K_ZLP = 1, K_NACK = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fw_wr_en = 1'b0;
  logic [7:0]    fw_wr_data = '0;
  logic          fw_commit = 1'b0;
  logic [CW-1:0] fw_commit_len = '0;
  logic          fw_clear = 1'b0;
  logic          iso_mode = 1'b0;
  logic          sof = 1'b0;
  logic          in_token = 1'b0;
  logic          usb_rd = 1'b0;
  logic [7:0]    usb_rd_data;
  logic          flag_empty, flag_full, flag_underrun, flag_overflow;
  logic [1:0]    set_count;
  logic          resp_valid;
  logic [1:0]    resp_kind;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_tx_frame_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
    .fw_commit(fw_commit), .fw_commit_len(fw_commit_len), .fw_clear(fw_clear),
    .iso_mode(iso_mode), .sof(sof), .in_token(in_token), .usb_rd(usb_rd),
    .usb_rd_data(usb_rd_data), .flag_empty(flag_empty), .flag_full(flag_full),
    .flag_underrun(flag_underrun), .flag_overflow(flag_overflow),
    .set_count(set_count), .resp_valid(resp_valid), .resp_kind(resp_kind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input int b);
    fw_wr_en = 1'b1; fw_wr_data = 8'(b);
    @(negedge clk);
    fw_wr_en = 1'b0;
  endtask

  task automatic commit(input int n);
    fw_commit = 1'b1; fw_commit_len = CW'(n);
    @(negedge clk);
    fw_commit = 1'b0;
  endtask

  task automatic clear();
    fw_clear = 1'b1;
    @(negedge clk);
    fw_clear = 1'b0;
  endtask

  task automatic frame();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic tok(input string tag, input int k);
    in_token = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
    chk({tag, " resp_valid"}, int'(resp_valid), 1);
    chk({tag, " resp_kind"}, int'(resp_kind), k);
  endtask

  task automatic rd(input string tag, input int exp);
    usb_rd = 1'b1;
    @(negedge clk);
    usb_rd = 1'b0;
    chk(tag, int'(usb_rd_data), exp);
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " empty"}, int'(flag_empty), 1);
    chk({tag, " full"}, int'(flag_full), 0);
    chk({tag, " underrun"}, int'(flag_underrun), 0);
    chk({tag, " overflow"}, int'(flag_overflow), 0);
    chk({tag, " count"}, int'(set_count), 0);
    chk({tag, " resp_valid"}, int'(resp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    chk_idle("R1 reset");

    // Bulk-style sweep over every set length, wrapping the store
    for (int len = 1; len <= DEPTH; len++) begin
      for (int i = 0; i < len; i++) begin
        wr((len << 4) + i);
        if (i == 0) chk("R2 empty after first byte", int'(flag_empty), 0);
      end
      chk("R3 full at DEPTH", int'(flag_full), (len == DEPTH) ? 1 : 0);
      commit(len);
      chk("R2 empty after commit", int'(flag_empty), 1);
      chk("R4 count one", int'(set_count), 1);
      tok("R9 data offered", K_DATA);
      for (int i = 0; i < len; i++) rd("R6 byte order", (len << 4) + i);
      idle();
      chk("R6 retired", int'(set_count), 0);
      tok("R9 nack when none", K_NACK);
    end

    // Two sets back to back, then zero-length commit, then overflow
    for (int i = 0; i < 3; i++) wr(8'h30 + i);
    commit(3);
    for (int i = 0; i < 2; i++) wr(8'h40 + i);
    commit(2);
    chk("R4 count two", int'(set_count), 2);
    commit(0);
    chk("R4 zero commit ignored", int'(set_count), 2);
    wr(8'h77);
    commit(1);
    chk("R5 overflow flag", int'(flag_overflow), 1);
    chk("R5 count kept", int'(set_count), 2);
    chk("R5 staged kept", int'(flag_empty), 0);
    for (int i = 0; i < 3; i++) rd("R6 first set", 8'h30 + i);
    idle();
    chk("R6 count after first", int'(set_count), 1);
    for (int i = 0; i < 2; i++) rd("R6 second set", 8'h40 + i);
    idle();
    chk("R5 overflow sticky", int'(flag_overflow), 1);
    clear();
    chk_idle("R1 clear");

    // Writes while full are dropped
    for (int i = 0; i < DEPTH + 2; i++) wr(8'h50 + i);
    chk("R3 full", int'(flag_full), 1);
    commit(DEPTH);
    for (int i = 0; i < DEPTH; i++) rd("R3 dropped writes", 8'h50 + i);
    idle();
    chk("R3 not full", int'(flag_full), 0);
    clear();

    // Bulk-style underrun
    wr(8'h61); wr(8'h62);
    commit(4);
    rd("R7 byte a", 8'h61);
    rd("R7 byte b", 8'h62);
    usb_rd = 1'b1; idle(); usb_rd = 1'b0;
    chk("R7 underrun immediate", int'(flag_underrun), 1);
    wr(8'h63);
    usb_rd = 1'b1; idle(); usb_rd = 1'b0;
    tok("R8 nack on underrun", K_NACK);
    chk("R7 set held", int'(set_count), 1);
    chk("R7 underrun sticky", int'(flag_underrun), 1);
    clear();
    chk_idle("R7 clear");

    // Isochronous: hidden until SOF, retire at SOF
    iso_mode = 1'b1;
    tok("R10 zlp with none", K_ZLP);
    wr(8'h71); wr(8'h72); wr(8'h73);
    commit(3);
    chk("R4 iso count", int'(set_count), 1);
    tok("R10 hidden before sof", K_ZLP);
    frame();
    tok("R10 offered after sof", K_DATA);
    usb_rd = 1'b1; sof = 1'b1; idle(); usb_rd = 1'b0; sof = 1'b0;
    for (int i = 0; i < 3; i++) rd("R11 read after ignored one", 8'h71 + i);
    tok("R10 zlp after sent", K_ZLP);
    chk("R11 retire deferred", int'(set_count), 1);
    frame();
    chk("R11 retire at sof", int'(set_count), 0);

    // Isochronous underrun deferred to SOF
    wr(8'h81);
    commit(2);
    frame();
    rd("R11 iso byte", 8'h81);
    usb_rd = 1'b1; idle(); usb_rd = 1'b0;
    idle();
    chk("R11 underrun deferred", int'(flag_underrun), 0);
    frame();
    chk("R11 underrun at sof", int'(flag_underrun), 1);
    tok("R8 iso nack", K_NACK);
    clear();

    // Isochronous late set discarded at SOF
    wr(8'hA0); wr(8'hA1);
    commit(2);
    frame();
    wr(8'hB0); wr(8'hB1);
    commit(2);
    chk("R12 two held", int'(set_count), 2);
    tok("R10 old set offered", K_DATA);
    frame();
    chk("R12 stale dropped", int'(set_count), 1);
    tok("R12 new set offered", K_DATA);
    rd("R12 new byte 0", 8'hB0);
    rd("R12 new byte 1", 8'hB1);
    frame();
    chk("R12 drained", int'(set_count), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule